// File: doc/BRIEF.md
# VCO Lock Calibration Sequencer

This block brings a radio synthesizer out of reset and finds a voltage-controlled oscillator setting that makes the PLL lock. A single start pulse launches a fixed burst of serial register writes. The block then steps through a table of standard oscillator settings, all on channel 1. After each setting it clears the lock-status register through a simple register port, reads it back, and treats an all-zero low nibble as lock.

The first setting that locks ends the search. If none of the settings tried gives lock, the block writes a fixed auto-calibration setting instead. In both cases it closes with one baseband control write and raises a done flag. The stored selection it reports is the locking index plus one, or zero on the fallback path. A separate flag says whether a standard setting locked. Every serial word leaves through a valid/ready request channel. Channel retuning after the search belongs to other logic, and so does the serial bit timing.

Top module: `vco_lock_search`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, locked_o and err_o are low, sel_o is 0, and no serial, register-write or register-read request is active.
- R2: A start_i pulse seen while idle begins a new run, clears done_o, locked_o, err_o and sel_o, and raises busy_o on the next cycle. A start_i pulse during a run has no effect on the request stream or on the results.
- R3: Each serial word is {register[3:0], value[19:0]} on sw_data_o. A word stays valid and unchanged until sw_ready_i accepts it.
- R4: A run opens with these serial writes, in this order: r4=0x0002B, r5=0x19E4F, r6=0xF81AD, r7=0x3FFFE, r0=0x25F9C, r1=0x00047, r2=0x00999, r3=0x07602, r3=0x46063. The register-0 mode words 0x25F98, 0x25F9A, 0x25F94 and 0x27FD4 follow, in that order.
- R5: Candidate i is written as r1=0x00047, then r2=0x00999, then r3=0x40000|E[i]. For i=0..10, E is 0x664D, 0x666D, 0x665D, 0x667D, 0x6643, 0x6663, 0x6653, 0x6673, 0x664B, 0x666B, 0x665B.
- R6: After each candidate, one register write of 0x000F goes to STAT_ADDR (default 0x2F0). The cycle after it, a one-cycle read of STAT_ADDR is issued. A response on reg_rvalid_i is accepted from the cycle after the read onward.
- R7: A response whose bits [3:0] are all zero is a lock, whatever its upper bits hold. The first lock ends the search and sets locked_o=1 and sel_o=i+1.
- R8: Only candidates 0 to NUM_CFG-2 are tried. If none locks, the block writes r1=0x06847, r2=0x00999, r3=0x46662, then finishes with locked_o=0 and sel_o=0.
- R9: Every completed run ends with a register write of 0x0006 to BB_ADDR (default 0x0CB). done_o rises on the following cycle and holds until the next start.
- R10: If no response arrives within RD_TIMEOUT wait cycles after a read, err_o is set and the block returns to idle. It issues no further requests and leaves done_o low. A response in the last of those cycles is still accepted.
- R11: busy_o is high from the cycle after an accepted start until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| sw_valid_o | output | 1 | Serial write request valid |
| sw_ready_i | input | 1 | Serial write request accepted |
| sw_data_o | output | 24 | Serial word {register, value} |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | REG_AW | Register address |
| reg_wdata_o | output | REG_DW | Register write data |
| reg_rvalid_i | input | 1 | Read response valid |
| reg_rdata_i | input | REG_DW | Read response data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed |
| locked_o | output | 1 | A standard setting locked |
| err_o | output | 1 | Status read timed out |
| sel_o | output | $clog2(NUM_CFG+1) | Stored selection |

## Verification
Lock is placed at candidate 0, at a middle candidate, and at the last candidate tried. A fourth case puts lock only at the untried final index. Between them these runs separate correct stop points, index-plus-one encoding and the dropped last table. Non-locking responses carry a nonzero low nibble, and the locking response carries set upper bits, so a check on the wrong bits shows up. Read latency is varied up to the last accepted cycle, and one run is silent, so the timeout boundary is pinned from both sides. Serial back-pressure, plus a start pulse in mid-run, tests that words are held and that extra starts are ignored.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int RF_REG_W  = 4;
  localparam int RF_VAL_W  = 20;
  localparam int RF_WORD_W = RF_REG_W + RF_VAL_W;
  localparam int INIT_STEPS = 13;
  localparam int CAND_STEPS = 3;
  localparam int VCO_ENT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_CAND, ST_ACK, ST_RD, ST_WAIT, ST_FALL, ST_FINAL
  } vls_state_e;

  typedef enum logic [1:0] {PH_INIT, PH_CAND, PH_FALL} vls_phase_e;

  function automatic logic [RF_WORD_W-1:0] rf_word(input logic [RF_REG_W-1:0] r,
                                                   input logic [RF_VAL_W-1:0] v);
    return {r, v};
  endfunction
endpackage

// File: rtl/vls_vco_rom.sv
module vls_vco_rom #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]              idx_i,
  output logic [vls_pkg::VCO_ENT_W-1:0] entry_o
);
  always_comb begin
    case (idx_i)
      IDX_W'(0):  entry_o = 16'h664D;
      IDX_W'(1):  entry_o = 16'h666D;
      IDX_W'(2):  entry_o = 16'h665D;
      IDX_W'(3):  entry_o = 16'h667D;
      IDX_W'(4):  entry_o = 16'h6643;
      IDX_W'(5):  entry_o = 16'h6663;
      IDX_W'(6):  entry_o = 16'h6653;
      IDX_W'(7):  entry_o = 16'h6673;
      IDX_W'(8):  entry_o = 16'h664B;
      IDX_W'(9):  entry_o = 16'h666B;
      IDX_W'(10): entry_o = 16'h665B;
      default:    entry_o = 16'h0000;
    endcase
  end
endmodule

// File: rtl/vls_word_gen.sv
module vls_word_gen
  import vls_pkg::*;
(
  input  vls_phase_e             phase_i,
  input  logic [3:0]             step_i,
  input  logic [VCO_ENT_W-1:0]   vco_i,
  output logic [RF_WORD_W-1:0]   word_o
);
  logic [RF_VAL_W-1:0] vco_word;
  assign vco_word = 20'h40000 | {4'h0, vco_i};

  always_comb begin
    word_o = '0;
    unique case (phase_i)
      PH_INIT: begin
        case (step_i)
          4'd0:    word_o = rf_word(4'd4, 20'h0002B);
          4'd1:    word_o = rf_word(4'd5, 20'h19E4F);
          4'd2:    word_o = rf_word(4'd6, 20'hF81AD);
          4'd3:    word_o = rf_word(4'd7, 20'h3FFFE);
          4'd4:    word_o = rf_word(4'd0, 20'h25F9C);
          4'd5:    word_o = rf_word(4'd1, 20'h00047);
          4'd6:    word_o = rf_word(4'd2, 20'h00999);
          4'd7:    word_o = rf_word(4'd3, 20'h07602);
          4'd8:    word_o = rf_word(4'd3, 20'h46063);
          4'd9:    word_o = rf_word(4'd0, 20'h25F98);
          4'd10:   word_o = rf_word(4'd0, 20'h25F9A);
          4'd11:   word_o = rf_word(4'd0, 20'h25F94);
          4'd12:   word_o = rf_word(4'd0, 20'h27FD4);
          default: word_o = '0;
        endcase
      end
      PH_CAND: begin
        case (step_i)
          4'd0:    word_o = rf_word(4'd1, 20'h00047);
          4'd1:    word_o = rf_word(4'd2, 20'h00999);
          default: word_o = rf_word(4'd3, vco_word);
        endcase
      end
      PH_FALL: begin
        case (step_i)
          4'd0:    word_o = rf_word(4'd1, 20'h06847);
          4'd1:    word_o = rf_word(4'd2, 20'h00999);
          default: word_o = rf_word(4'd3, 20'h46662);
        endcase
      end
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/vls_rd_timer.sv
module vls_rd_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + CW'(1);
  end

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/vco_lock_search.sv
module vco_lock_search
  import vls_pkg::*;
#(
  parameter int NUM_CFG    = 11,
  parameter int RD_TIMEOUT = 16,
  parameter int REG_AW     = 10,
  parameter int REG_DW     = 16,
  parameter logic [REG_AW-1:0] STAT_ADDR = 10'h2F0,
  parameter logic [REG_AW-1:0] BB_ADDR   = 10'h0CB,
  localparam int IDX_W = $clog2(NUM_CFG + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  output logic                  sw_valid_o,
  input  logic                  sw_ready_i,
  output logic [RF_WORD_W-1:0]  sw_data_o,
  output logic                  reg_wr_o,
  output logic                  reg_rd_o,
  output logic [REG_AW-1:0]     reg_addr_o,
  output logic [REG_DW-1:0]     reg_wdata_o,
  input  logic                  reg_rvalid_i,
  input  logic [REG_DW-1:0]     reg_rdata_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  locked_o,
  output logic                  err_o,
  output logic [IDX_W-1:0]      sel_o
);
  localparam int TRY_CNT = NUM_CFG - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRY_CNT - 1);

  vls_state_e         state_q;
  logic [3:0]         step_q;
  logic [IDX_W-1:0]   idx_q, sel_q;
  logic               done_q, locked_q, err_q;

  vls_phase_e         phase;
  logic [VCO_ENT_W-1:0] vco_entry;
  logic               hs, last_step, expire, lock_hit;
  logic               unused_rdata;

  assign unused_rdata = ^reg_rdata_i[REG_DW-1:4];

  assign phase = (state_q == ST_INIT) ? PH_INIT :
                 (state_q == ST_FALL) ? PH_FALL : PH_CAND;

  vls_vco_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i   (idx_q),
    .entry_o (vco_entry)
  );

  vls_word_gen u_word (
    .phase_i (phase),
    .step_i  (step_q),
    .vco_i   (vco_entry),
    .word_o  (sw_data_o)
  );

  vls_rd_timer #(.LIMIT(RD_TIMEOUT)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_WAIT),
    .run_i    ((state_q == ST_WAIT) && !reg_rvalid_i),
    .expire_o (expire)
  );

  assign sw_valid_o  = (state_q == ST_INIT) || (state_q == ST_CAND) || (state_q == ST_FALL);
  assign hs          = sw_valid_o && sw_ready_i;
  assign last_step   = (state_q == ST_INIT) ? (step_q == 4'(INIT_STEPS - 1))
                                            : (step_q == 4'(CAND_STEPS - 1));
  assign reg_wr_o    = (state_q == ST_ACK) || (state_q == ST_FINAL);
  assign reg_rd_o    = (state_q == ST_RD);
  assign reg_addr_o  = (state_q == ST_FINAL) ? BB_ADDR : STAT_ADDR;
  assign reg_wdata_o = (state_q == ST_FINAL) ? REG_DW'(16'h0006) : REG_DW'(16'h000F);
  assign lock_hit    = (reg_rdata_i[3:0] == 4'h0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      idx_q    <= '0;
      sel_q    <= '0;
      done_q   <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_INIT;
          step_q   <= '0;
          idx_q    <= '0;
          sel_q    <= '0;
          done_q   <= 1'b0;
          locked_q <= 1'b0;
          err_q    <= 1'b0;
        end
        ST_INIT: if (hs) begin
          if (last_step) begin
            state_q <= ST_CAND;
            step_q  <= '0;
          end else step_q <= step_q + 4'd1;
        end
        ST_CAND: if (hs) begin
          if (last_step) begin
            state_q <= ST_ACK;
            step_q  <= '0;
          end else step_q <= step_q + 4'd1;
        end
        ST_ACK: state_q <= ST_RD;
        ST_RD:  state_q <= ST_WAIT;
        ST_WAIT: begin
          if (reg_rvalid_i) begin
            if (lock_hit) begin
              locked_q <= 1'b1;
              sel_q    <= idx_q + IDX_W'(1);
              state_q  <= ST_FINAL;
            end else if (idx_q == LAST_IDX) begin
              state_q <= ST_FALL;
              step_q  <= '0;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_CAND;
            end
          end else if (expire) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FALL: if (hs) begin
          if (last_step) begin
            state_q <= ST_FINAL;
            step_q  <= '0;
          end else step_q <= step_q + 4'd1;
        end
        ST_FINAL: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign locked_o = locked_q;
  assign err_o    = err_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/vls_chk.sv
module vls_chk #(
  parameter int NUM_CFG = 11,
  parameter int REG_AW  = 10,
  parameter int REG_DW  = 16,
  parameter int SEL_W   = 4,
  parameter logic [REG_AW-1:0] BB_ADDR = 10'h0CB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_valid_o,
  input logic              sw_ready_i,
  input logic [23:0]       sw_data_o,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic [REG_AW-1:0] reg_addr_o,
  input logic [REG_DW-1:0] reg_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              locked_o,
  input logic              err_o,
  input logic [SEL_W-1:0]  sel_o
);
  // R3
  sw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o && !sw_ready_i |=> sw_valid_o && $stable(sw_data_o));

  // R6
  ack_then_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o && (reg_wdata_o == REG_DW'(16'h000F)) |=> reg_rd_o);

  // R6
  read_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o && !reg_wr_o && !sw_valid_o);

  // R9
  done_after_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(reg_wr_o) && ($past(reg_addr_o) == BB_ADDR)
                      && ($past(reg_wdata_o) == REG_DW'(16'h0006)));

  // R7
  locked_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (sel_o != '0) && (sel_o <= SEL_W'(NUM_CFG - 1)));

  // R8
  fallback_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !locked_o |-> sel_o == '0);

  // R10
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o && !locked_o);

  // R11
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

bind vco_lock_search vls_chk #(
  .NUM_CFG (NUM_CFG),
  .REG_AW  (REG_AW),
  .REG_DW  (REG_DW),
  .SEL_W   (IDX_W),
  .BB_ADDR (BB_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_valid_o  (sw_valid_o),
  .sw_ready_i  (sw_ready_i),
  .sw_data_o   (sw_data_o),
  .reg_wr_o    (reg_wr_o),
  .reg_rd_o    (reg_rd_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .locked_o    (locked_o),
  .err_o       (err_o),
  .sel_o       (sel_o)
);

// File: tb/tb_vco_lock_search.sv
module tb_vco_lock_search;
  localparam int NUM_CFG = 11;
  localparam int RD_TO   = 8;
  localparam int NTRY    = NUM_CFG - 1;
  localparam logic [9:0] STAT = 10'h2F0;
  localparam logic [9:0] BBA  = 10'h0CB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sw_valid, sw_ready = 1'b1;
  logic [23:0] sw_data;
  logic        reg_wr, reg_rd;
  logic [9:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        rvalid = 1'b0;
  logic [15:0] rdata = '0;
  logic        busy, done, locked, err;
  logic [3:0]  sel;

  vco_lock_search #(.NUM_CFG(NUM_CFG), .RD_TIMEOUT(RD_TO)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sw_valid_o(sw_valid), .sw_ready_i(sw_ready), .sw_data_o(sw_data),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rvalid_i(rvalid), .reg_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .locked_o(locked), .err_o(err), .sel_o(sel)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  logic [39:0] exp_q[$];
  string       tag_q[$];
  int lock_at = -1, lat = 1, silent_at = -1, rd_cnt = 0, pcnt = 0;
  bit stall_en = 0, pend = 0;
  logic [15:0] pdata;
  logic [15:0] vco_tab [NUM_CFG] = '{16'h664D, 16'h666D, 16'h665D, 16'h667D,
    16'h6643, 16'h6663, 16'h6653, 16'h6673, 16'h664B, 16'h666B, 16'h665B};

  task automatic chk(input bit ok, input string tag, input logic [39:0] act,
                     input logic [39:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] kind, input logic [11:0] a,
                      input logic [23:0] d, input string tag);
    exp_q.push_back({kind, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [39:0] got);
    if (exp_q.size() == 0) chk(0, "R2 unexpected request", got, '0);
    else begin
      logic [39:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got == e, t, got, e);
    end
  endtask

  // Reference model: expected request stream for one run
  task automatic build(input int lk, input int sil);
    logic [23:0] init_w [13] = '{24'h40002B, 24'h519E4F, 24'h6F81AD, 24'h73FFFE,
      24'h025F9C, 24'h100047, 24'h200999, 24'h307602, 24'h346063,
      24'h025F98, 24'h025F9A, 24'h025F94, 24'h027FD4};
    bit hit = 0;
    for (int k = 0; k < 13; k++) push(4'd0, 12'd0, init_w[k], "R4 init word");
    for (int i = 0; i < NTRY; i++) begin
      push(4'd0, 12'd0, 24'h100047, "R5 cand synth");
      push(4'd0, 12'd0, 24'h200999, "R5 cand divide");
      push(4'd0, 12'd0, {4'd3, 20'h40000 | {4'h0, vco_tab[i]}}, "R5 cand vco");
      push(4'd1, 12'(STAT), 24'h00000F, "R6 ack write");
      push(4'd2, 12'(STAT), 24'h0, "R6 status read");
      if (i == sil) return;
      if (i == lk) begin hit = 1; break; end
    end
    if (!hit) begin
      push(4'd0, 12'd0, 24'h106847, "R8 fallback synth");
      push(4'd0, 12'd0, 24'h200999, "R8 fallback divide");
      push(4'd0, 12'd0, 24'h346662, "R8 fallback vco");
    end
    push(4'd1, 12'(BBA), 24'h000006, "R9 final write");
  endtask

  always @(negedge clk_i) begin
    cyc++;
    sw_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
    rvalid = 1'b0;
    if (pend) begin
      if (pcnt <= 1) begin rvalid = 1'b1; rdata = pdata; pend = 0; end
      else pcnt--;
    end
    if (rst_ni) begin
      if (sw_valid && sw_ready) observe({4'd0, 12'd0, sw_data});
      if (reg_wr) observe({4'd1, 12'(reg_addr), 24'(reg_wdata)});
      if (reg_rd) begin
        observe({4'd2, 12'(reg_addr), 24'd0});
        if (rd_cnt != silent_at) begin
          pend = 1; pcnt = lat;
          pdata = (rd_cnt == lock_at) ? 16'hFFF0 : (16'hA5A0 | (16'h1 << (rd_cnt % 4)));
        end
        rd_cnt++;
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input int lk, input int l, input int sil, input bit st,
                     input bit poke, input string name);
    int n = 0;
    lock_at = lk; lat = l; silent_at = sil; stall_en = st; rd_cnt = 0;
    build(lk, sil);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy, {"R11 busy after start ", name}, 40'(busy), 1);
    while (busy && n < 5000) begin
      @(negedge clk_i); n++;
      if (poke && n == 20) start_i = 1'b1;
      if (poke && n == 21) start_i = 1'b0;
    end
    @(negedge clk_i);
    chk(exp_q.size() == 0, {"R2 stream complete ", name}, 40'(exp_q.size()), 0);
    exp_q.delete(); tag_q.delete();
    if (sil >= 0) begin
      chk(err == 1 && done == 0, {"R10 timeout flags ", name}, {err, done}, 2'b10);
      chk(busy == 0, {"R10 idle after timeout ", name}, 40'(busy), 0);
    end else if (lk >= 0 && lk < NTRY) begin
      chk(done && locked && !err, {"R7 lock flags ", name}, {done, locked, err}, 3'b110);
      chk(sel == 4'(lk + 1), {"R7 selection ", name}, 40'(sel), 40'(lk + 1));
    end else begin
      chk(done && !locked && !err, {"R8 fallback flags ", name}, {done, locked, err}, 3'b100);
      chk(sel == 0, {"R8 selection ", name}, 40'(sel), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy, done, locked, err, sel} == '0, "R1 reset outputs",
        {busy, done, locked, err, sel}, 0);
    chk(!sw_valid && !reg_wr && !reg_rd, "R1 no requests in reset",
        {sw_valid, reg_wr, reg_rd}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(0, 1, -1, 0, 0, "lock at 0");
    run(4, 3, -1, 1, 1, "lock at 4 stalled");
    chk(done, "R9 done holds in idle", 40'(done), 1);
    run(NTRY - 1, RD_TO, -1, 0, 0, "lock at last tried, max latency");
    run(NTRY, 2, -1, 1, 0, "lock only at untried index");
    run(-1, 1, 2, 0, 0, "silent status read");
    run(1, 2, -1, 0, 0, "run after timeout");
    chk(!err, "R2 start clears err", 40'(err), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule